// File: doc/BRIEF.md
# Multi-Chip Packed-Pixel Display RAM Port

This block is the host-side memory port of one column driver in a group of up to four identical drivers. All members of the group sit on one asynchronous host bus made of chip select, write strobe, output enable, a 17-bit address and a data bus that is 8 or 16 bits wide. The host sees the whole panel as one flat memory area and never decodes a select for each chip. A 2-bit strap tells each chip which quadrant of that area it owns. The block decodes the panel address and serves only the accesses that fall in its own quadrant.

Locally the block holds a 240-column by 160-row picture at 2 bits per pixel. Pixels are packed side by side, and the lowest-numbered column sits in the most significant bits of a bus word. Host writes pass through a two-flop synchronizer and are committed on the rising edge of the write strobe. Host reads are combinational and are steered through a separate output-enable signal. A second, clocked port hands one whole display line to the gray-scale output stage. Only the horizontal panel orientation is handled.

Top module: `pxp_panel_port`

## Requirements
- R1: After reset, `disp_data` is all zeros and `data_oe` is low.
- R2: The panel row is addr[16:8] and the column byte is addr[7:0]. Strap bit 0 set means the chip owns panel rows 160..319 (local row = panel row − 160); clear means rows 0..159. Strap bit 1 set means it owns column bytes 0x3C..0x77 (local byte = column byte − 0x3C); clear means 0x00..0x3B.
- R3: On a 16-bit bus a word holds 8 pixels. The even byte goes to data[15:8] and the odd byte to data[7:0], and address bit 0 is ignored.
- R4: On an 8-bit bus, address bit 0 = 0 selects the even byte, whose four pixels lie in columns with lower numbers than those of the odd byte.
- R5: `data_oe` is high only while `cs_n` and `oe_n` are both low and the address falls in the chip's own quadrant. Otherwise `data_oe` is low and `data_out` is zero.
- R6: A write is committed once for each rising edge of `we_n`, seen through a two-flop synchronizer while `cs_n` is low. A strobe edge while `cs_n` is high writes nothing.
- R7: Writes outside the chip's quadrant are ignored. This covers another chip's quadrant, column bytes at or above 0x78, and panel rows at or above 320.
- R8: `disp_data` returns the whole 480-bit local row selected by `disp_row` one clock later. Column 0 is in bits [479:478] and local byte b is in bits [479−8b : 472−8b].
- R9: When a host write and the display port hit the same row in the same cycle, the display port returns the data from before the write.
- R10: A `disp_row` value of 160 or more returns all zeros one clock later.
- R11: While `dir_vert` is high, every host access is ignored: nothing is written and `data_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | 2 | Strap giving the quadrant position |
| dir_vert | input | 1 | Vertical orientation select (accesses ignored when high) |
| cs_n | input | 1 | Shared chip select, active low |
| we_n | input | 1 | Shared write strobe, active low |
| oe_n | input | 1 | Shared output enable, active low |
| addr | input | 17 | Flat panel address |
| data_in | input | DATA_W | Host write data |
| data_out | output | DATA_W | Host read data |
| data_oe | output | 1 | Drive enable for the host data bus |
| disp_row | input | 9 | Local row requested by the display stage |
| disp_data | output | 2*COLS | Full pixel row for the display stage |

## Verification
The bench builds two copies of the block on one shared bus, both with the full 240x160 geometry. One has a 16-bit data bus and the strap for the upper-row, upper-column quadrant. The other has an 8-bit bus and the strap for quadrant zero. This brings into reach the row and column offset subtraction, the last word of the last row, byte-lane order on both bus widths, and two chips on one bus that ignore each other's traffic.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
  localparam int unsigned PXP_COLS   = 240;
  localparam int unsigned PXP_ROWS   = 160;
  localparam int unsigned PXP_ADDR_W = 17;

  // Decoded host access: local row and local byte within the row.
  typedef struct packed {
    logic       hit;
    logic [8:0] row;
    logic [7:0] col_byte;
  } pxp_dec_t;
endpackage

// File: rtl/pxp_rst_sync.sv
module pxp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/pxp_addr_dec.sv
module pxp_addr_dec
  import pxp_pkg::*;
#(
  parameter int unsigned ROWS      = PXP_ROWS,
  parameter int unsigned ROW_BYTES = PXP_COLS / 4,
  parameter int unsigned DATA_W    = 16
) (
  input  logic [PXP_ADDR_W-1:0] addr,
  input  logic [1:0]            chip_id,
  input  logic                  dir_vert,
  output pxp_dec_t              dec
);
  localparam int unsigned BPW        = DATA_W / 8;
  localparam logic [8:0]  ROWS_L     = 9'(ROWS);
  localparam logic [9:0]  ROWS2_L    = 10'(2 * ROWS);
  localparam logic [7:0]  BYTES_L    = 8'(ROW_BYTES);
  localparam logic [8:0]  BYTES2_L   = 9'(2 * ROW_BYTES);
  localparam logic [7:0]  ALIGN_MASK = ~8'(BPW - 1);

  logic [8:0] prow;
  logic [7:0] pcol;
  logic       row_upper, col_upper, row_in, col_in;

  always_comb begin
    prow      = addr[16:8];
    pcol      = addr[7:0];
    row_upper = (prow >= ROWS_L);
    col_upper = (pcol >= BYTES_L);
    row_in    = ({1'b0, prow} < ROWS2_L);
    col_in    = ({1'b0, pcol} < BYTES2_L);
    dec.row      = row_upper ? (prow - ROWS_L) : prow;
    dec.col_byte = (col_upper ? (pcol - BYTES_L) : pcol) & ALIGN_MASK;
    dec.hit      = ~dir_vert & row_in & col_in &
                   (row_upper == chip_id[0]) & (col_upper == chip_id[1]);
  end

  // R7: an accepted access always lands inside the local array
  always_comb begin
    if (dec.hit === 1'b1) begin
      assert_local_range_R7: assert (dec.row < ROWS_L && dec.col_byte < BYTES_L);
    end
  end
endmodule

// File: rtl/pxp_strobe_sync.sv
module pxp_strobe_sync (
  input  logic clk,
  input  logic srst_n,
  input  logic we_n,
  input  logic cs_n,
  output logic commit
);
  logic we_s1_q, we_s2_q, we_s3_q, cs_s1_q, cs_s2_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      we_s1_q <= 1'b1;
      we_s2_q <= 1'b1;
      we_s3_q <= 1'b1;
      cs_s1_q <= 1'b1;
      cs_s2_q <= 1'b1;
    end else begin
      we_s1_q <= we_n;
      we_s2_q <= we_s1_q;
      we_s3_q <= we_s2_q;
      cs_s1_q <= cs_n;
      cs_s2_q <= cs_s1_q;
    end
  end

  always_comb commit = we_s2_q & ~we_s3_q & ~cs_s2_q;

  // R6: one strobe edge yields a single commit cycle
  assert_single_commit_R6: assert property (@(posedge clk) disable iff (!srst_n)
    commit |=> !commit);
endmodule

// File: rtl/pxp_row_ram.sv
module pxp_row_ram #(
  parameter int unsigned ROWS   = 160,
  parameter int unsigned ROW_W  = 480,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  logic [8:0]        wr_row,
  input  logic [7:0]        wr_byte,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [8:0]        host_row,
  input  logic [7:0]        host_byte,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [8:0]        disp_row,
  output logic [ROW_W-1:0]  disp_data
);
  localparam int unsigned RW        = $clog2(ROWS);
  localparam int unsigned BW        = $clog2(ROW_W);
  localparam int unsigned ROW_BYTES = ROW_W / 8;
  localparam logic [8:0]  ROWS_L    = 9'(ROWS);
  localparam logic [7:0]  BYTES_L   = 8'(ROW_BYTES);
  localparam logic [BW-1:0] TOP_LANE = BW'(ROW_W - DATA_W);

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] disp_next;
  logic [BW-1:0]    wr_base, rd_base;

  function automatic logic [BW-1:0] lane_base(input logic [7:0] b);
    return TOP_LANE - BW'({b, 3'b000});
  endfunction

  always_comb begin
    wr_base = lane_base(wr_byte);
    rd_base = lane_base(host_byte);
    host_rdata = '0;
    if (host_row < ROWS_L && host_byte < BYTES_L)
      host_rdata = mem[host_row[RW-1:0]][rd_base +: DATA_W];
    disp_next = '0;
    if (disp_row < ROWS_L)
      disp_next = mem[disp_row[RW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_row[RW-1:0]][wr_base +: DATA_W] <= wr_data;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) disp_data <= '0;
    else         disp_data <= disp_next;
  end

  // R10: rows past the array read as zero
  assert_oob_row_zero_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (disp_row >= ROWS_L) |=> (disp_data == '0));
endmodule

// File: rtl/pxp_panel_port.sv
module pxp_panel_port
  import pxp_pkg::*;
#(
  parameter int unsigned COLS   = PXP_COLS,
  parameter int unsigned ROWS   = PXP_ROWS,
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            chip_id,
  input  logic                  dir_vert,
  input  logic                  cs_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic [PXP_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     data_in,
  output logic [DATA_W-1:0]     data_out,
  output logic                  data_oe,
  input  logic [8:0]            disp_row,
  output logic [2*COLS-1:0]     disp_data
);
  localparam int unsigned ROW_W     = 2 * COLS;
  localparam int unsigned ROW_BYTES = ROW_W / 8;

  logic              srst_n, commit, wr_en;
  pxp_dec_t          dec;
  logic [DATA_W-1:0] host_rdata;

  pxp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  pxp_addr_dec #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .DATA_W(DATA_W)) u_dec (
    .addr(addr), .chip_id(chip_id), .dir_vert(dir_vert), .dec(dec));

  pxp_strobe_sync u_strobe (
    .clk(clk), .srst_n(srst_n), .we_n(we_n), .cs_n(cs_n), .commit(commit));

  always_comb begin
    wr_en    = commit & dec.hit;
    data_oe  = ~cs_n & ~oe_n & dec.hit;
    data_out = data_oe ? host_rdata : '0;
  end

  pxp_row_ram #(.ROWS(ROWS), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .srst_n(srst_n),
    .wr_en(wr_en), .wr_row(dec.row), .wr_byte(dec.col_byte), .wr_data(data_in),
    .host_row(dec.row), .host_byte(dec.col_byte), .host_rdata(host_rdata),
    .disp_row(disp_row), .disp_data(disp_data));

  // R5: the bus is driven only under an active select and output enable
  assert_drive_gate_R5: assert property (@(posedge clk) disable iff (!srst_n)
    data_oe |-> (!cs_n && !oe_n));

  // R11: vertical orientation silences the host port
  assert_vert_silent_R11: assert property (@(posedge clk) disable iff (!srst_n)
    dir_vert |-> (!data_oe && !wr_en));
endmodule

// File: tb/pxp_panel_port_bench.sv
`timescale 1ns/100ps
module pxp_panel_port_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   sa, sb;
  logic         dir_vert, cs_n, we_n, oe_n;
  logic [16:0]  addr;
  logic [15:0]  din;
  logic [8:0]   drow_a, drow_b;
  logic [15:0]  dout_a;
  logic [7:0]   dout_b;
  logic         oe_a, oe_b;
  logic [479:0] disp_a, disp_b;
  int           n_chk = 0;
  int           n_err = 0;
  logic         done = 1'b0;

  always #2.5 clk = ~clk;

  pxp_panel_port #(.DATA_W(16)) u_pxp_panel_port (
    .clk(clk), .rst_n(rst_n), .chip_id(sa), .dir_vert(dir_vert),
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .data_in(din),
    .data_out(dout_a), .data_oe(oe_a), .disp_row(drow_a), .disp_data(disp_a));

  pxp_panel_port #(.DATA_W(8)) u_pxp_panel_port_b8 (
    .clk(clk), .rst_n(rst_n), .chip_id(sb), .dir_vert(dir_vert),
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .data_in(din[7:0]),
    .data_out(dout_b), .data_oe(oe_b), .disp_row(drow_b), .disp_data(disp_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [16:0] a, input logic [15:0] d, input logic sel);
    @(negedge clk);
    addr = a; din = d; cs_n = ~sel; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic [16:0] a, input logic oe_on,
                          output logic [15:0] da, output logic ea,
                          output logic [7:0] db, output logic eb);
    @(negedge clk);
    addr = a; cs_n = 1'b0; oe_n = ~oe_on;
    #1;
    da = dout_a; ea = oe_a; db = dout_b; eb = oe_b;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic peek_a(input logic [8:0] r, output logic [479:0] v);
    @(negedge clk); drow_a = r;
    @(negedge clk); v = disp_a;
  endtask

  task automatic peek_b(input logic [8:0] r, output logic [479:0] v);
    @(negedge clk); drow_b = r;
    @(negedge clk); v = disp_b;
  endtask

  task automatic t_reset();
    chk("R1 disp_data zero", 32'(disp_a[479:464] | disp_b[479:464]), 32'h0);
    chk("R1 data_oe low", {30'd0, oe_a, oe_b}, 32'h0);
  endtask

  task automatic t_word_rw();
    logic [15:0] da; logic ea; logic [7:0] db; logic eb; logic [479:0] v;
    bus_write(17'h0A03C, 16'hABCD, 1'b1);   // chip 3: local row 0, byte 0
    bus_read(17'h0A03C, 1'b1, da, ea, db, eb);
    chk("R2 quadrant read data", 32'(da), 32'hABCD);
    chk("R2 quadrant read drive", 32'(ea), 32'h1);
    bus_read(17'h0A03D, 1'b1, da, ea, db, eb);
    chk("R3 odd address ignored on 16-bit", 32'(da), 32'hABCD);
    peek_a(9'd0, v);
    chk("R8 row 0 leading word", 32'(v[479:464]), 32'hABCD);
  endtask

  task automatic t_read_gating();
    logic [15:0] da; logic ea; logic [7:0] db; logic eb;
    bus_read(17'h0A03C, 1'b0, da, ea, db, eb);
    chk("R5 oe_n high no drive", {15'd0, ea, da}, 32'h0);
    bus_read(17'h00000, 1'b1, da, ea, db, eb);
    chk("R5 foreign quadrant no drive", 32'(ea), 32'h0);
  endtask

  task automatic t_foreign_writes();
    logic [15:0] da; logic ea; logic [7:0] db; logic eb;
    bus_write(17'h0003C, 16'h1111, 1'b1);   // chip 2 territory
    bus_write(17'h0A078, 16'h9999, 1'b1);   // column byte past span
    bus_write(17'h0A03C, 16'h5555, 1'b0);   // strobe with cs_n high
    bus_read(17'h0A03C, 1'b1, da, ea, db, eb);
    chk("R7 foreign writes leave data", 32'(da), 32'hABCD);
    chk("R6 no write without select", 32'(da), 32'hABCD);
    bus_read(17'h0A078, 1'b1, da, ea, db, eb);
    chk("R7 column past span not claimed", 32'(ea), 32'h0);
    bus_read(17'h14000, 1'b1, da, ea, db, eb);
    chk("R7 row 320 not claimed", 32'(ea), 32'h0);
  endtask

  task automatic t_last_word();
    logic [479:0] v;
    bus_write(17'h13F76, 16'h1234, 1'b1);   // local row 159, bytes 58..59
    peek_a(9'd159, v);
    chk("R2 last word of last row", 32'(v[15:0]), 32'h1234);
  endtask

  task automatic t_byte_bus();
    logic [15:0] da; logic ea; logic [7:0] db; logic eb; logic [479:0] v;
    bus_write(17'h00000, 16'h00C3, 1'b1);
    bus_write(17'h00001, 16'h005A, 1'b1);
    bus_read(17'h00001, 1'b1, da, ea, db, eb);
    chk("R4 odd byte read", {23'd0, eb, db}, {23'd0, 1'b1, 8'h5A});
    chk("R5 other chip silent", 32'(ea), 32'h0);
    peek_b(9'd0, v);
    chk("R4 even byte leads row", 32'(v[479:464]), 32'hC35A);
  endtask

  task automatic t_collision();
    logic [479:0] v;
    bus_write(17'h0A53C, 16'h1111, 1'b1);   // local row 5
    @(negedge clk);
    drow_a = 9'd5; addr = 17'h0A53C; din = 16'h2222; cs_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 same-cycle read returns old", 32'(disp_a[479:464]), 32'h1111);
    @(negedge clk);
    chk("R9 next cycle returns new", 32'(disp_a[479:464]), 32'h2222);
    cs_n = 1'b1;
    peek_a(9'd5, v);
  endtask

  task automatic t_oob_row();
    logic [479:0] v;
    peek_a(9'd200, v);
    chk("R10 out-of-range row zero", 32'(v[479:448] | v[31:0]), 32'h0);
  endtask

  task automatic t_vertical();
    logic [15:0] da; logic ea; logic [7:0] db; logic eb;
    @(negedge clk); dir_vert = 1'b1;
    bus_write(17'h0A03C, 16'h7777, 1'b1);
    bus_read(17'h0A03C, 1'b1, da, ea, db, eb);
    chk("R11 no drive when vertical", 32'(ea), 32'h0);
    @(negedge clk); dir_vert = 1'b0;
    bus_read(17'h0A03C, 1'b1, da, ea, db, eb);
    chk("R11 vertical write ignored", 32'(da), 32'hABCD);
  endtask

  initial begin
    rst_n = 1'b0; sa = 2'b11; sb = 2'b00; dir_vert = 1'b0;
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    drow_a = '0; drow_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_word_rw();
    t_read_gating();
    t_foreign_writes();
    t_last_word();
    t_byte_bus();
    t_collision();
    t_oob_row();
    t_vertical();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule